// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the five-state coherence tag (Modified, Owned, Exclusive, Shared, Invalid) for every line of a small cache. It reacts to two sources of work: requests from the local processor (read, write, evict) and transactions snooped from peer caches on a shared bus. For each, it decides whether a bus transaction is needed, tells the data path what to do with the line, and moves the line to its next state. Data arrays, replacement and bus arbitration live elsewhere. The controller only raises the control strobes the data path acts on.

A processor request is held on `req_valid` until `req_done` pulses. A request that needs the bus raises `bus_req_valid` with a command. It completes in the cycle the arbiter returns `bus_grant`, and the line changes state at that clock edge. The bus command is recomputed every cycle from the line's current state, so a snoop that changes the line while a request waits changes the command it issues. A snoop is handled in the cycle it is presented. While `snp_valid` is high, the local side issues nothing and completes nothing.

The Owned state lets a dirty line be shared: a peer read is served cache-to-cache and memory is not written. The parameter `WR_OWNED_UPDATE` selects what a local write to an Owned line does. With 0, the write invalidates the sharers. With 1, it broadcasts an update to them.

Top module: `moesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cur_state` reports the line selected by `req_idx` with encoding Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R2: A local read (`req_op`=0) of a line in any valid state completes in the same cycle with no bus request and no state change.
- R3: A local read of an Invalid line requests bus command read (1). On grant, `dp_fill` pulses and the line becomes Exclusive if `bus_shared_in` is low, or Shared if it is high.
- R4: A local write (`req_op`=1) to a Modified line completes with no bus request and stays Modified. A write to an Exclusive line completes with no bus request and becomes Modified.
- R5: A local write to a Shared line requests invalidate (3) and, on grant, becomes Modified without `dp_fill`. A write to an Invalid line requests read-exclusive (2) and, on grant, pulses `dp_fill` and becomes Modified.
- R6: A local write to an Owned line requests invalidate (3) and ends Modified when `WR_OWNED_UPDATE`=0. It requests update (4) and stays Owned when `WR_OWNED_UPDATE`=1.
- R7: A local evict (`req_op`=2) of a Modified or Owned line requests writeback (5). On grant, `dp_writeback` pulses and the line becomes Invalid. Evicting an Exclusive or Shared line completes with no bus request and leaves it Invalid. Evicting an Invalid line changes nothing.
- R8: A snooped read (`snp_cmd`=1) of a Modified line raises `dp_supply` and moves the line to Owned. On an Owned line it raises `dp_supply` and the line stays Owned. An Exclusive line moves to Shared and a Shared line stays Shared. `dp_writeback` stays low throughout.
- R9: A snooped read-exclusive (2) or invalidate (3) moves any valid line to Invalid, raising `dp_supply` in that cycle if the line was Modified or Owned.
- R10: A snooped update (4) on a Shared line raises `dp_take_upd` and the line stays Shared. A snooped writeback (5) or update changes no line state.
- R11: `snp_shared` is high during a snoop exactly when the snooped line is in a valid state.
- R12: While `snp_valid` is high, `bus_req_valid` and `req_done` are low and no local request changes any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local request present, held until `req_done` |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 no operation |
| req_idx | input | IDX_W | Line addressed by the local request |
| req_done | output | 1 | Local request completes at this clock edge |
| cur_state | output | 3 | Coherence state of line `req_idx` |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 3 | 1 read, 2 read-exclusive, 3 invalidate, 4 update, 5 writeback |
| bus_req_idx | output | IDX_W | Line the bus transaction refers to |
| bus_grant | input | 1 | Requested transaction takes place this cycle |
| bus_shared_in | input | 1 | A peer holds the line, sampled on a read grant |
| snp_valid | input | 1 | Peer transaction snooped this cycle |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_req_cmd` |
| snp_idx | input | IDX_W | Line the snooped transaction refers to |
| snp_shared | output | 1 | This cache holds the snooped line |
| dp_supply | output | 1 | Data path sources the line to the requesting peer |
| dp_writeback | output | 1 | Data path writes the line to memory |
| dp_fill | output | 1 | Data path accepts fill data for the local request |
| dp_take_upd | output | 1 | Data path accepts broadcast update data |

## Verification
On every cycle, the assertions check several relationships. Snoops always take priority over the local side. Fill and writeback strobes only appear together with a matching granted command. Read hits never reach the bus. A dirty line hit by a peer read, read-exclusive or invalidate is always sourced and never written back. A silent Exclusive-to-Modified write lands, and all lines are Invalid right after reset. Only the bench's sweeps can show the complete state successor for every pair of start state and operation. The same holds for the effect of `bus_shared_in` on a fill and for the divergent Owned-line write outcome of the two parameter settings. Checking these requires driving each line into a known state first.

// File: rtl/moesi_pkg.sv
// Shared encodings for the coherence controller.
// Assumes all parties on the bus use the same command encoding.
package moesi_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_SHR = 3'd1,
        LS_EXC = 3'd2,
        LS_OWN = 3'd3,
        LS_MOD = 3'd4
    } line_state_e;

    typedef enum logic [2:0] {
        BC_NONE   = 3'd0,
        BC_READ   = 3'd1,
        BC_READX  = 3'd2,
        BC_INVAL  = 3'd3,
        BC_UPDATE = 3'd4,
        BC_WBACK  = 3'd5
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;

endpackage

// File: rtl/moesi_state_array.sv
// Per-line coherence state storage with one write port and two read
// ports (local side and snoop side). Assumes at most one write per cycle.
module moesi_state_array
    import moesi_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int IDX_W  = $clog2(NLINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_state_e      wr_state,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_state_e      rd_a_state,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_state_e      rd_b_state
);

    line_state_e lines [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // Hold one line's state; clear to Invalid on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lines[g] <= LS_INV;
            else if (wr_en && wr_idx == IDX_W'(g))
                lines[g] <= wr_state;
        end
    end

    // Read ports are plain muxes over the line registers.
    always_comb begin
        rd_a_state = lines[rd_a_idx];
        rd_b_state = lines[rd_b_idx];
    end

endmodule

// File: rtl/moesi_local_ctrl.sv
// Decodes a local processor request against the line's current state.
// Decides whether a bus transaction is needed, which command it is, and
// the state the line ends in. Assumes the arbiter never grants in a cycle
// that also carries a snoop, and that the request is held until done.
module moesi_local_ctrl
    import moesi_pkg::*;
#(
    parameter bit WR_OWNED_UPDATE = 1'b0
) (
    input  logic        req_valid,
    input  req_op_e     req_op,
    input  line_state_e cur_state,
    input  logic        snp_busy,
    input  logic        bus_grant,
    input  logic        bus_shared_in,
    output logic        bus_req_valid,
    output bus_cmd_e    bus_req_cmd,
    output logic        req_done,
    output logic        upd_en,
    output line_state_e upd_state,
    output logic        dp_fill,
    output logic        dp_writeback
);

    logic need_bus;
    logic active;

    // Choose the bus command and the final state for this request.
    always_comb begin
        need_bus    = 1'b0;
        bus_req_cmd = BC_NONE;
        upd_state   = cur_state;
        unique case (req_op)
            OP_READ: begin
                if (cur_state == LS_INV) begin
                    need_bus    = 1'b1;
                    bus_req_cmd = BC_READ;
                    upd_state   = bus_shared_in ? LS_SHR : LS_EXC;
                end
            end
            OP_WRITE: begin
                unique case (cur_state)
                    LS_EXC: upd_state = LS_MOD;
                    LS_OWN: begin
                        need_bus = 1'b1;
                        if (WR_OWNED_UPDATE) begin
                            bus_req_cmd = BC_UPDATE;
                            upd_state   = LS_OWN;
                        end else begin
                            bus_req_cmd = BC_INVAL;
                            upd_state   = LS_MOD;
                        end
                    end
                    LS_SHR: begin
                        need_bus    = 1'b1;
                        bus_req_cmd = BC_INVAL;
                        upd_state   = LS_MOD;
                    end
                    LS_INV: begin
                        need_bus    = 1'b1;
                        bus_req_cmd = BC_READX;
                        upd_state   = LS_MOD;
                    end
                    default: upd_state = cur_state;
                endcase
            end
            OP_EVICT: begin
                if (cur_state == LS_MOD || cur_state == LS_OWN) begin
                    need_bus    = 1'b1;
                    bus_req_cmd = BC_WBACK;
                end
                upd_state = LS_INV;
            end
            default: upd_state = cur_state;
        endcase
    end

    // Handshake with the bus and completion toward the processor.
    always_comb begin
        active        = req_valid && !snp_busy;
        bus_req_valid = active && need_bus;
        req_done      = active && (!need_bus || bus_grant);
        upd_en        = req_done && (upd_state != cur_state);
        dp_fill       = active && need_bus && bus_grant &&
                        (bus_req_cmd == BC_READ || bus_req_cmd == BC_READX);
        dp_writeback  = active && need_bus && bus_grant &&
                        (bus_req_cmd == BC_WBACK);
    end

endmodule

// File: rtl/moesi_snoop_ctrl.sv
// Reacts to a transaction snooped from a peer cache in a single cycle.
// Assumes peers obey the protocol (no update arrives for an owned line).
module moesi_snoop_ctrl
    import moesi_pkg::*;
(
    input  logic        snp_valid,
    input  bus_cmd_e    snp_cmd,
    input  line_state_e snp_state,
    output logic        snp_shared,
    output logic        dp_supply,
    output logic        dp_take_upd,
    output logic        upd_en,
    output line_state_e upd_state
);

    logic dirty;

    // Decide response strobes and the line's next state.
    always_comb begin
        dirty       = (snp_state == LS_MOD) || (snp_state == LS_OWN);
        snp_shared  = snp_valid && (snp_state != LS_INV);
        dp_supply   = 1'b0;
        dp_take_upd = 1'b0;
        upd_state   = snp_state;
        if (snp_valid) begin
            unique case (snp_cmd)
                BC_READ: begin
                    dp_supply = dirty;
                    if (snp_state == LS_MOD) upd_state = LS_OWN;
                    if (snp_state == LS_EXC) upd_state = LS_SHR;
                end
                BC_READX, BC_INVAL: begin
                    dp_supply = dirty;
                    upd_state = LS_INV;
                end
                BC_UPDATE: dp_take_upd = (snp_state == LS_SHR);
                default:   upd_state   = snp_state;
            endcase
        end
        upd_en = snp_valid && (upd_state != snp_state);
    end

endmodule

// File: rtl/moesi_coherence_ctrl.sv
// Top of the coherence controller: state array plus local and snoop
// decoders. A snoop has priority; the local side stalls while one is
// present, so at most one line update happens per cycle.
module moesi_coherence_ctrl
    import moesi_pkg::*;
#(
    parameter int NLINES          = 4,
    parameter bit WR_OWNED_UPDATE = 1'b0,
    localparam int IDX_W          = $clog2(NLINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_done,
    output logic [2:0]       cur_state,
    output logic             bus_req_valid,
    output logic [2:0]       bus_req_cmd,
    output logic [IDX_W-1:0] bus_req_idx,
    input  logic             bus_grant,
    input  logic             bus_shared_in,
    input  logic             snp_valid,
    input  logic [2:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_shared,
    output logic             dp_supply,
    output logic             dp_writeback,
    output logic             dp_fill,
    output logic             dp_take_upd
);

    line_state_e      loc_state, snp_state;
    line_state_e      loc_next, snp_next;
    logic             loc_upd, snp_upd;
    bus_cmd_e         loc_cmd;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    line_state_e      wr_state;

    moesi_state_array #(.NLINES(NLINES), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
        .rd_a_idx(req_idx), .rd_a_state(loc_state),
        .rd_b_idx(snp_idx), .rd_b_state(snp_state)
    );

    moesi_local_ctrl #(.WR_OWNED_UPDATE(WR_OWNED_UPDATE)) u_local (
        .req_valid(req_valid), .req_op(req_op_e'(req_op)),
        .cur_state(loc_state), .snp_busy(snp_valid),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(loc_cmd),
        .req_done(req_done), .upd_en(loc_upd), .upd_state(loc_next),
        .dp_fill(dp_fill), .dp_writeback(dp_writeback)
    );

    moesi_snoop_ctrl u_snoop (
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)),
        .snp_state(snp_state), .snp_shared(snp_shared),
        .dp_supply(dp_supply), .dp_take_upd(dp_take_upd),
        .upd_en(snp_upd), .upd_state(snp_next)
    );

    // Merge the two update sources, snoop first.
    always_comb begin
        wr_en    = snp_upd || loc_upd;
        wr_idx   = snp_upd ? snp_idx  : req_idx;
        wr_state = snp_upd ? snp_next : loc_next;
    end

    // Drive the port-level views.
    always_comb begin
        cur_state   = loc_state;
        bus_req_cmd = loc_cmd;
        bus_req_idx = req_idx;
    end

endmodule

// File: rtl/moesi_coherence_checker.sv
// Property checker bound to the coherence controller.
module moesi_coherence_checker #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_done,
    input logic [2:0]       cur_state,
    input logic             bus_req_valid,
    input logic [2:0]       bus_req_cmd,
    input logic             bus_grant,
    input logic             snp_valid,
    input logic [2:0]       snp_cmd,
    input logic [2:0]       snp_state,
    input logic             dp_supply,
    input logic             dp_writeback,
    input logic             dp_fill
);

    assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cur_state == 3'd0);

    assert_read_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && cur_state != 3'd0) |-> !bus_req_valid);

    assert_fill_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dp_fill |-> (bus_grant && bus_req_valid &&
                     (bus_req_cmd == 3'd1 || bus_req_cmd == 3'd2)));

    assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && cur_state == 3'd2 && !snp_valid)
        |=> (req_idx != $past(req_idx) || cur_state == 3'd4));

    assert_wback_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dp_writeback |-> (bus_grant && bus_req_valid && bus_req_cmd == 3'd5));

    assert_dirty_sourced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == 3'd1 || snp_cmd == 3'd2 || snp_cmd == 3'd3) &&
         (snp_state == 3'd3 || snp_state == 3'd4))
        |-> (dp_supply && !dp_writeback));

    assert_snoop_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (!bus_req_valid && !req_done));

    assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dp_fill, dp_writeback, dp_supply}));

endmodule

bind moesi_coherence_ctrl moesi_coherence_checker #(.IDX_W(IDX_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_idx(req_idx), .req_done(req_done), .cur_state(cur_state),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_grant(bus_grant), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_state(snp_state), .dp_supply(dp_supply),
    .dp_writeback(dp_writeback), .dp_fill(dp_fill)
);

// File: tb/moesi_coherence_ctrl_test.sv
// Sweeps every start state against every local operation and every
// snooped command, on one instance per Owned-write policy.
module moesi_coherence_ctrl_test;

    localparam int NL = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [IW-1:0] req_idx = '0;
    logic          bus_grant = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [2:0]    snp_cmd = 3'd0;
    logic [IW-1:0] snp_idx = '0;

    logic          a_done, a_brv, a_shr, a_sup, a_wb, a_fill, a_upd;
    logic [2:0]    a_st, a_cmd;
    logic [IW-1:0] a_bidx;
    logic          b_done, b_brv, b_shr, b_sup, b_wb, b_fill, b_upd;
    logic [2:0]    b_st, b_cmd;
    logic [IW-1:0] b_bidx;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    moesi_coherence_ctrl #(.NLINES(NL), .WR_OWNED_UPDATE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_done(a_done), .cur_state(a_st),
        .bus_req_valid(a_brv), .bus_req_cmd(a_cmd), .bus_req_idx(a_bidx),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_shared(a_shr), .dp_supply(a_sup), .dp_writeback(a_wb),
        .dp_fill(a_fill), .dp_take_upd(a_upd));

    moesi_coherence_ctrl #(.NLINES(NL), .WR_OWNED_UPDATE(1'b1)) uut_upd (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_done(b_done), .cur_state(b_st),
        .bus_req_valid(b_brv), .bus_req_cmd(b_cmd), .bus_req_idx(b_bidx),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_shared(b_shr), .dp_supply(b_sup), .dp_writeback(b_wb),
        .dp_fill(b_fill), .dp_take_upd(b_upd));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outcome of a local request (states I0 S1 E2 O3 M4).
    function automatic void local_model(input int st, input int op, input int shr,
                                        input int updm, output int need,
                                        output int cmd, output int nxt);
        need = 0; cmd = 0; nxt = st;
        if (op == 0 && st == 0) begin need = 1; cmd = 1; nxt = shr ? 1 : 2; end
        if (op == 1) begin
            if (st == 2) nxt = 4;
            if (st == 1) begin need = 1; cmd = 3; nxt = 4; end
            if (st == 0) begin need = 1; cmd = 2; nxt = 4; end
            if (st == 3) begin need = 1; cmd = updm ? 4 : 3; nxt = updm ? 3 : 4; end
        end
        if (op == 2) begin
            if (st == 3 || st == 4) begin need = 1; cmd = 5; end
            nxt = 0;
        end
    endfunction

    // Expected outcome of a snooped command.
    function automatic void snoop_model(input int st, input int cmd, output int sup,
                                        output int shr, output int take, output int nxt);
        int dirty;
        dirty = (st == 3 || st == 4) ? 1 : 0;
        shr = (st != 0) ? 1 : 0;
        sup = 0; take = 0; nxt = st;
        if (cmd == 1) begin
            sup = dirty;
            if (st == 4) nxt = 3;
            if (st == 2) nxt = 1;
        end
        if (cmd == 2 || cmd == 3) begin sup = dirty; nxt = 0; end
        if (cmd == 4) take = (st == 1) ? 1 : 0;
    endfunction

    // One granted local request without checks.
    task automatic raw_req(input int op, input int idx, input int shr);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_idx = IW'(idx);
        bus_grant = 1'b1; bus_shared_in = shr[0];
        @(negedge clk);
        req_valid = 1'b0; bus_grant = 1'b0; bus_shared_in = 1'b0;
    endtask

    task automatic raw_snoop(input int cmd, input int idx);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_idx = IW'(idx);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 3'd0;
    endtask

    // Drive line idx into state st through the ports.
    task automatic set_state(input int idx, input int st);
        raw_req(2, idx, 0);
        case (st)
            1: raw_req(0, idx, 1);
            2: raw_req(0, idx, 0);
            3: begin raw_req(1, idx, 0); raw_snoop(1, idx); end
            4: raw_req(1, idx, 0);
            default: ;
        endcase
    endtask

    task automatic run_local(input int st, input int op, input int shr, input int idx);
        int need, cmd, nxt, bneed, bcmd, bnxt;
        string rq;
        local_model(st, op, shr, 0, need, cmd, nxt);
        local_model(st, op, shr, 1, bneed, bcmd, bnxt);
        rq = (op == 0) ? (st == 0 ? "R3" : "R2") :
             (op == 1) ? (st == 3 ? "R6" : (st >= 2 ? "R4" : "R5")) : "R7";
        set_state(idx, st);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_idx = IW'(idx);
        bus_shared_in = shr[0];
        #2;
        chk({rq, " start state"}, a_st, st);
        chk({rq, " bus request"}, a_brv, need);
        chk({rq, " done without grant"}, a_done, 1 - need);
        chk({rq, " bus index"}, a_bidx, idx);
        if (need != 0) chk({rq, " bus command"}, a_cmd, cmd);
        if (bneed != 0) chk({rq, " bus command (update policy)"}, b_cmd, bcmd);
        if (need != 0) begin
            bus_grant = 1'b1;
            #2;
            chk({rq, " done on grant"}, a_done, 1);
            chk({rq, " fill strobe"}, a_fill, (cmd == 1 || cmd == 2) ? 1 : 0);
            chk({rq, " writeback strobe"}, a_wb, (cmd == 5) ? 1 : 0);
        end
        @(negedge clk);
        req_valid = 1'b0; bus_grant = 1'b0; bus_shared_in = 1'b0;
        #2;
        chk({rq, " final state"}, a_st, nxt);
        chk({rq, " final state (update policy)"}, b_st, bnxt);
    endtask

    task automatic run_snoop(input int st, input int cmd, input int idx);
        int sup, shr, take, nxt, other;
        string rq;
        snoop_model(st, cmd, sup, shr, take, nxt);
        rq = (cmd == 1) ? "R8" : (cmd == 2 || cmd == 3) ? "R9" : "R10";
        other = (idx + 1) % NL;
        set_state(idx, st);
        set_state(other, 0);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 3'(cmd); snp_idx = IW'(idx);
        req_valid = 1'b1; req_op = 2'd1; req_idx = IW'(other);
        #2;
        chk("R11 snoop shared", a_shr, shr);
        chk({rq, " supply"}, a_sup, sup);
        chk({rq, " take update"}, a_upd, take);
        chk({rq, " no writeback"}, a_wb, 0);
        chk("R12 bus request held off", a_brv, 0);
        chk("R12 local done held off", a_done, 0);
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = 3'd0; req_valid = 1'b0; req_idx = IW'(idx);
        #2;
        chk({rq, " state after snoop"}, a_st, nxt);
        req_idx = IW'(other);
        #2;
        chk("R12 stalled line untouched", a_st, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) begin
            req_idx = IW'(i);
            #1;
            chk("R1 reset state", a_st, 0);
        end
        for (int s = 0; s < 5; s++)
            for (int op = 0; op < 3; op++)
                for (int sh = 0; sh < 2; sh++)
                    run_local(s, op, sh, (s + op + sh) % NL);
        for (int s = 0; s < 5; s++)
            for (int c = 1; c < 6; c++)
                run_snoop(s, c, (s + c) % NL);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule